// File: doc/BRIEF.md
# Shared Buffer Ownership Arbiter

This block decides which of three masters owns a single shared data buffer: a host CPU, a USB engine and a transfer coprocessor. Each master raises a request and holds it. When the buffer has no owner, the block grants it to the requesting master with the highest priority. Once a master holds the grant, it keeps the buffer with no time limit until it asserts its release line. Requests from other masters stay pending while the buffer is owned and cannot take it away. At a release, the highest-priority master still requesting receives the grant on the next cycle.

The block also drives the select code for the buffer's access-port mux. It times each access made by the owner. A CPU access is slower and occupies the port for three cycles. A USB or coprocessor access takes one cycle. A busy flag and a ready pulse tell the owner when its access has finished.

Top module: `buf_arbiter`

## Requirements
- R1: After reset, no grant is active, the select code is 0 and busy_o and ready_o are low.
- R2: gnt_o has at most one bit set. sel_o is 0 when no bit is set, and 1, 2 or 3 when bit 0 (CPU), bit 1 (USB) or bit 2 (coprocessor) is set.
- R3: If the buffer has no owner at a clock edge and requests are present, the grant appears on the next cycle. It goes to the lowest-numbered requesting bit: CPU (bit 0) before USB (bit 1) before coprocessor (bit 2).
- R4: An owner keeps its grant for any number of cycles until its release is honoured. Requests from other masters, including higher-priority ones, do not change the grant.
- R5: An honoured release moves the grant on the next cycle to the highest-priority requester other than the releasing master. If no other master is requesting, the grant drops to none.
- R6: A master that drops its request before being granted is never granted for that request.
- R7: A release asserted by a master that is not the owner has no effect.
- R8: An access started by the CPU owner (acc_i bit 0) keeps busy_o high for 3 cycles. ready_o is high only in the third of those cycles.
- R9: An access started by the USB or coprocessor owner keeps busy_o high for 1 cycle, and ready_o is high in that same cycle.
- R10: An access strobe from a master that does not own the buffer starts no access.
- R11: A release asserted while an access is in progress and not in its ready cycle is ignored. A release in the ready cycle is honoured.
- R12: The owner may start a new access in the ready cycle of the previous one. The access then continues with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 3 | Request per master (bit 0 CPU, bit 1 USB, bit 2 coprocessor) |
| rel_i | input | 3 | Release per master |
| acc_i | input | 3 | Access start strobe per master |
| gnt_o | output | 3 | One-hot grant, all zero when the buffer is free |
| sel_o | output | 2 | Access-port mux select: 0 none, 1 CPU, 2 USB, 3 coprocessor |
| busy_o | output | 1 | Owner's access in progress |
| ready_o | output | 1 | Owner's access completes this cycle |

## Verification
The bench targets the following corner cases:
- A higher-priority request arriving mid-ownership. A preempting design would move the grant here.
- A release in the middle of a CPU access. A design that honoured it would cut the three-cycle access short.
- A release and a fresh access start in the ready cycle. An off-by-one counter would insert a gap or refuse the handoff.
- A release from a non-owner, and a request withdrawn before it was granted. A design that latched requests would grant a master that had given up.

Long random traffic then compares every output against a behavioural model on every cycle.

// File: rtl/buf_arb_pkg.sv
package buf_arb_pkg;
  localparam int NUM_REQ = 3;
  localparam int IDX_CPU = 0;
  localparam int IDX_USB = 1;
  localparam int IDX_COP = 2;
  localparam int SEL_W   = $clog2(NUM_REQ + 1);

  // lowest index wins
  function automatic logic [NUM_REQ-1:0] pick_first(input logic [NUM_REQ-1:0] r);
    logic [NUM_REQ-1:0] v;
    v = '0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (r[i]) begin
        v    = '0;
        v[i] = 1'b1;
      end
    end
    return v;
  endfunction
endpackage

// File: rtl/arb_owner.sv
module arb_owner
  import buf_arb_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic [NUM_REQ-1:0] rel_i,
  input  logic               rel_allow_i,
  output logic [NUM_REQ-1:0] gnt_o,
  output logic               rel_fire_o
);
  logic [NUM_REQ-1:0] gnt_q, gnt_d;

  always_comb begin
    rel_fire_o = (|(rel_i & gnt_q)) & rel_allow_i;
    gnt_d      = gnt_q;
    if (gnt_q == '0)     gnt_d = pick_first(req_i);
    else if (rel_fire_o) gnt_d = pick_first(req_i & ~gnt_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gnt_q <= '0;
    else         gnt_q <= gnt_d;
  end

  assign gnt_o = gnt_q;

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R2
  AST_FREE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == '0 && req_i != '0) |=> (gnt_o != '0)); // R3
  AST_NO_PREEMPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && (rel_i & gnt_o) == '0) |=> $stable(gnt_o)); // R4
  AST_GRANT_REQUESTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && gnt_o != $past(gnt_o)) |-> (($past(req_i) & gnt_o) != '0)); // R6
endmodule

// File: rtl/arb_access_timer.sv
module arb_access_timer
  import buf_arb_pkg::*;
#(
  parameter int CPU_CYC = 3,
  parameter int DEV_CYC = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] gnt_i,
  input  logic [NUM_REQ-1:0] acc_i,
  input  logic               rel_fire_i,
  output logic               busy_o,
  output logic               ready_o,
  output logic               rel_allow_o
);
  localparam int MAX_CYC = (CPU_CYC > DEV_CYC) ? CPU_CYC : DEV_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start;
  logic             idle_or_last;

  assign idle_or_last = (cnt_q <= CNT_W'(1));
  assign start        = (|(acc_i & gnt_i)) & idle_or_last & ~rel_fire_i;

  always_comb begin
    cnt_d = cnt_q;
    if (start)             cnt_d = gnt_i[IDX_CPU] ? CNT_W'(CPU_CYC) : CNT_W'(DEV_CYC);
    else if (cnt_q != '0)  cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign busy_o      = (cnt_q != '0);
  assign ready_o     = (cnt_q == CNT_W'(1));
  assign rel_allow_o = idle_or_last;

  generate
    if (CPU_CYC >= 2) begin : g_cpu_chk
      AST_CPU_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start && gnt_i[IDX_CPU]) |=> (busy_o && !ready_o)); // R8
    end
    if (DEV_CYC == 1) begin : g_dev_chk
      AST_DEV_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start && !gnt_i[IDX_CPU]) |=> (busy_o && ready_o)); // R9
    end
  endgenerate
  AST_FOREIGN_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((acc_i & gnt_i) == '0 && !busy_o) |=> !busy_o); // R10
endmodule

// File: rtl/arb_sel_enc.sv
module arb_sel_enc
  import buf_arb_pkg::*;
(
  input  logic [NUM_REQ-1:0] gnt_i,
  output logic [SEL_W-1:0]   sel_o
);
  logic [NUM_REQ-1:0][SEL_W-1:0] term;

  generate
    for (genvar g = 0; g < NUM_REQ; g++) begin : g_term
      assign term[g] = gnt_i[g] ? SEL_W'(g + 1) : '0;
    end
  endgenerate

  always_comb begin
    sel_o = '0;
    for (int i = 0; i < NUM_REQ; i++) sel_o = sel_o | term[i];
  end
endmodule

// File: rtl/buf_arbiter.sv
module buf_arbiter
  import buf_arb_pkg::*;
#(
  parameter int CPU_CYC = 3,
  parameter int DEV_CYC = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic [NUM_REQ-1:0] rel_i,
  input  logic [NUM_REQ-1:0] acc_i,
  output logic [NUM_REQ-1:0] gnt_o,
  output logic [SEL_W-1:0]   sel_o,
  output logic               busy_o,
  output logic               ready_o
);
  logic rel_allow;
  logic rel_fire;

  arb_owner u_owner (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .rel_i      (rel_i),
    .rel_allow_i(rel_allow),
    .gnt_o      (gnt_o),
    .rel_fire_o (rel_fire)
  );

  arb_access_timer #(
    .CPU_CYC(CPU_CYC),
    .DEV_CYC(DEV_CYC)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gnt_i      (gnt_o),
    .acc_i      (acc_i),
    .rel_fire_i (rel_fire),
    .busy_o     (busy_o),
    .ready_o    (ready_o),
    .rel_allow_o(rel_allow)
  );

  arb_sel_enc u_sel (
    .gnt_i(gnt_o),
    .sel_o(sel_o)
  );

  AST_SEL_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == '0) == (gnt_o == '0)); // R2
  AST_RELEASE_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !ready_o) |=> $stable(gnt_o)); // R11
endmodule

// File: tb/tb_buf_arbiter.sv
module tb_buf_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] req = '0, rel = '0, acc = '0;
  logic [2:0] gnt;
  logic [1:0] sel;
  logic       busy, ready;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string tag = "R1";

  // behavioural reference
  int m_owner = -1;
  int m_cnt   = 0;

  always #10 clk = ~clk;

  buf_arbiter dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .rel_i(rel), .acc_i(acc),
    .gnt_o(gnt), .sel_o(sel), .busy_o(busy), .ready_o(ready)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_owner = -1;
      m_cnt   = 0;
    end else begin
      bit fire, st;
      int nxt;
      fire = (m_owner >= 0) && rel[m_owner] && (m_cnt <= 1);
      st   = (m_owner >= 0) && acc[m_owner] && (m_cnt <= 1) && !fire;
      if (st)             m_cnt = (m_owner == 0) ? 3 : 1;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      nxt = m_owner;
      if (m_owner < 0 || fire) begin
        nxt = -1;
        for (int i = 2; i >= 0; i--)
          if (req[i] && i != m_owner) nxt = i;
      end
      m_owner = nxt;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [2:0] eg;
      logic [1:0] es;
      eg = (m_owner >= 0) ? 3'(1 << m_owner) : 3'b000;
      es = 2'(m_owner + 1);
      checks++;
      if (gnt !== eg || sel !== es || busy !== (m_cnt != 0) || ready !== (m_cnt == 1)) begin
        fails++;
        $display("FAIL %s: gnt=%b sel=%0d busy=%b ready=%b expected gnt=%b sel=%0d busy=%b ready=%b",
                 tag, gnt, sel, busy, ready, eg, es, m_cnt != 0, m_cnt == 1);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
      finish_run();
    end
  end

  task automatic cyc(input logic [2:0] r, input logic [2:0] l, input logic [2:0] a);
    @(negedge clk);
    req = r; rel = l; acc = a;
  endtask

  task automatic expect_gnt(input string t, input logic [2:0] e);
    @(negedge clk);
    checks++;
    if (gnt !== e) begin
      fails++;
      $display("FAIL %s: gnt=%b expected %b", t, gnt, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (gnt !== 3'b000 || sel !== 2'd0 || busy !== 1'b0 || ready !== 1'b0) begin
      fails++;
      $display("FAIL R1: gnt=%b sel=%0d busy=%b ready=%b expected 000 0 0 0", gnt, sel, busy, ready);
    end
    rst_n = 1'b1;

    tag = "R3";  cyc(3'b111, 0, 0);
    expect_gnt("R3", 3'b001);
    tag = "R4";  repeat (6) cyc(3'b111, 0, 0);
    tag = "R8";  cyc(3'b111, 0, 3'b001); repeat (4) cyc(3'b111, 0, 0);
    tag = "R12"; cyc(3'b111, 0, 3'b001); cyc(3'b111, 0, 0);
                 cyc(3'b111, 0, 0); cyc(3'b111, 0, 3'b001);
                 repeat (3) cyc(3'b111, 0, 0);
    tag = "R11"; cyc(3'b110, 0, 3'b001); cyc(3'b110, 3'b001, 0);
                 cyc(3'b110, 3'b001, 0);
    tag = "R5";  cyc(3'b110, 3'b001, 0); cyc(3'b110, 0, 0);
    expect_gnt("R5", 3'b010);
    tag = "R7";  cyc(3'b111, 3'b101, 0); repeat (2) cyc(3'b111, 0, 0);
    tag = "R10"; cyc(3'b111, 0, 3'b101); repeat (2) cyc(3'b111, 0, 0);
    tag = "R9";  cyc(3'b110, 0, 3'b010); cyc(3'b110, 0, 3'b010); repeat (2) cyc(3'b110, 0, 0);
    tag = "R6";  cyc(3'b010, 0, 0); cyc(3'b010, 3'b010, 0); repeat (2) cyc(3'b000, 0, 0);
    expect_gnt("R6", 3'b000);
    tag = "R9";  cyc(3'b100, 0, 0); cyc(3'b100, 0, 0); cyc(3'b100, 0, 3'b100);
                 cyc(3'b100, 0, 0); cyc(3'b100, 3'b100, 0); cyc(3'b000, 0, 0);

    tag = "R2";
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] r, l, a;
      r = 3'($urandom);
      l = (($urandom % 6) == 0) ? 3'($urandom) : 3'b000;
      a = 3'($urandom);
      cyc(r, l, a);
    end
    cyc(0, 3'b111, 0);
    repeat (4) cyc(0, 0, 0);
    finish_run();
  end
endmodule